// File: doc/BRIEF.md
# Multi-Mode 16-Bit Timer Counter

This block is a 16-bit up-counter assembled from two cascaded 8-bit halves. It sits beside a 16-bit data register that software loads one byte at a time. A 2-bit mode field selects one of three ways to use the pair. In interval mode the counter clears each time it reaches the data value; this toggles a square-wave pin and pulses a match request. In PWM mode the counter runs freely across its full range, and a pulse pin stays high while the data value exceeds the count. In capture mode a rising edge on an external event pin copies the count into the data register and restarts the counter. An overflow request pulses on every wrap, so software can extend the measured time past one counter period.

The counter advances only in clock cycles where the tick-enable input is high, so a prescaler outside the block sets the time base. Software writes registers through a simple write port and reads them through a read port with a one-cycle latency. The event pin is asynchronous and is synchronised inside the block.

Top module: `mmt_top`

## Requirements
- R1: Register addresses: 0 holds the mode in bits [1:0]; 1 is the low data byte and 2 the high data byte, which join as data = high*2^HALF_W + low; 3 and 4 read the low and high count halves. Read data appears one clock after the read address is presented.
- R2: In interval mode (mode 00), a tick on which the count equals the data value clears the counter, so matches repeat every data+1 ticks, counted from a clear.
- R3: In interval mode, every match toggles `tmr_out` and produces a one-clock `match_irq` pulse; `tmr_out` changes at no other time.
- R4: In PWM mode (mode 01), the counter is never cleared by a match. It wraps from all-ones to zero, giving a period of 2^(2*HALF_W) ticks, and `match_irq` pulses once per period, on the tick where the count equals the data value.
- R5: In PWM mode, `pwm_out` is high exactly when the data value is greater than the count, so it is high for data ticks of every period. In every other mode `pwm_out` is low.
- R6: In capture mode (mode 10), a rising edge on `cap_in`, passed through a two-flop synchroniser, copies the count into both data halves and clears the counter.
- R7: In capture mode, `ovf_irq` pulses for one clock on every tick that wraps the count from all-ones to zero. When a capture and a wrap happen in the same cycle, both take effect: the data register holds all-ones and `ovf_irq` pulses.
- R8: In capture mode, software writes to addresses 1 and 2 are ignored. The data register keeps the last captured value.
- R9: The counter advances only in cycles with `tick_en` high; with `tick_en` low it holds its value.
- R10: A write to address 0 clears the counter and `pwm_out` in the same cycle. Mode 11 keeps the counter stopped at its cleared value.
- R11: After reset, the mode, data, count, `rd_data` and all pin and request outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_en | input | 1 | Count enable, one tick per high cycle |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register write address |
| wr_data | input | HALF_W | Register write data |
| rd_addr | input | 3 | Register read address |
| rd_data | output | HALF_W | Registered read data |
| cap_in | input | 1 | Asynchronous capture event |
| tmr_out | output | 1 | Interval toggle output |
| pwm_out | output | 1 | PWM pulse output |
| match_irq | output | 1 | Compare-match request pulse |
| ovf_irq | output | 1 | Capture-mode overflow request pulse |

## Verification
A corrupted count shows up within one period. In interval mode the spacing between match pulses or the toggle pin goes wrong, and in PWM mode the number of high cycles in a 2^(2*HALF_W)-tick window differs from the data value. A wrong data register or a missed capture shows up as soon as the data bytes are read back after an event. A stuck carry between the halves changes both the period and the overflow count within a single wrap. Sweeps over many data values in a small 8-bit configuration cover short and long periods, zero and full-scale duty, and a capture landing on the same tick as a wrap.

// File: rtl/mmt_pkg.sv
`timescale 1ns/1ps
package mmt_pkg;

  typedef enum logic [1:0] {
    MODE_IVL = 2'b00,
    MODE_PWM = 2'b01,
    MODE_CAP = 2'b10,
    MODE_OFF = 2'b11
  } mmt_mode_e;

  localparam int ADDR_W = 3;

  localparam logic [ADDR_W-1:0] ADR_CTRL = 3'd0;
  localparam logic [ADDR_W-1:0] ADR_DLO  = 3'd1;
  localparam logic [ADDR_W-1:0] ADR_DHI  = 3'd2;
  localparam logic [ADDR_W-1:0] ADR_CLO  = 3'd3;
  localparam logic [ADDR_W-1:0] ADR_CHI  = 3'd4;

endpackage

// File: rtl/mmt_counter.sv
`timescale 1ns/1ps
// Up-counter built as a carry chain of equal-width halves.
module mmt_counter #(
  parameter int HALF_W     = 8,
  parameter int NUM_HALVES = 2,
  localparam int CW        = HALF_W * NUM_HALVES
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clr,
  input  logic          inc,
  output logic [CW-1:0] cnt,
  output logic [CW-1:0] cnt_nxt,
  output logic          wrap
);

  logic [NUM_HALVES:0] carry;

  assign carry[0] = inc;
  assign wrap     = carry[NUM_HALVES];

  for (genvar g = 0; g < NUM_HALVES; g++) begin : g_half
    logic [HALF_W-1:0] h_q;
    logic [HALF_W-1:0] h_nxt;

    assign carry[g+1] = carry[g] & (&h_q);

    always_comb begin
      if (clr)           h_nxt = '0;
      else if (carry[g]) h_nxt = h_q + 1'b1;
      else               h_nxt = h_q;
    end

    always_ff @(posedge clk) begin
      if (rst) h_q <= '0;
      else     h_q <= h_nxt;
    end

    assign cnt[g*HALF_W +: HALF_W]     = h_q;
    assign cnt_nxt[g*HALF_W +: HALF_W] = h_nxt;
  end

endmodule

// File: rtl/mmt_capsync.sv
`timescale 1ns/1ps
// Synchroniser chain with rising-edge detect on the settled stage.
module mmt_capsync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic async_in,
  output logic rise
);

  logic [STAGES-1:0] sync_q;
  logic              prev_q;

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk) begin
        if (rst) sync_q[0] <= 1'b0;
        else     sync_q[0] <= async_in;
      end
    end else begin : g_next
      always_ff @(posedge clk) begin
        if (rst) sync_q[s] <= 1'b0;
        else     sync_q[s] <= sync_q[s-1];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) prev_q <= 1'b0;
    else     prev_q <= sync_q[STAGES-1];
  end

  assign rise = sync_q[STAGES-1] & ~prev_q;

endmodule

// File: rtl/mmt_regs.sv
`timescale 1ns/1ps
// Mode and data registers; capture load overrides software writes.
module mmt_regs
  import mmt_pkg::*;
#(
  parameter int HALF_W = 8,
  localparam int CW    = 2 * HALF_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [HALF_W-1:0] wr_data,
  input  logic              cap_load,
  input  logic [CW-1:0]     cap_value,
  output mmt_mode_e         mode_q,
  output mmt_mode_e         mode_nxt,
  output logic [CW-1:0]     data_q,
  output logic [CW-1:0]     data_nxt,
  output logic              ctrl_wr
);

  logic sw_data_ok;

  assign ctrl_wr    = wr_en && (wr_addr == ADR_CTRL);
  assign sw_data_ok = wr_en && (mode_q != MODE_CAP);

  always_comb begin
    mode_nxt = mode_q;
    if (ctrl_wr) mode_nxt = mmt_mode_e'(wr_data[1:0]);
  end

  always_comb begin
    data_nxt = data_q;
    if (cap_load) begin
      data_nxt = cap_value;
    end else if (sw_data_ok && wr_addr == ADR_DLO) begin
      data_nxt[HALF_W-1:0] = wr_data;
    end else if (sw_data_ok && wr_addr == ADR_DHI) begin
      data_nxt[CW-1:HALF_W] = wr_data;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q <= MODE_IVL;
      data_q <= '0;
    end else begin
      mode_q <= mode_nxt;
      data_q <= data_nxt;
    end
  end

endmodule

// File: rtl/mmt_top.sv
`timescale 1ns/1ps
// Timer/counter with interval, PWM and capture personalities.
module mmt_top
  import mmt_pkg::*;
#(
  parameter int HALF_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick_en,
  input  logic              wr_en,
  input  logic [2:0]        wr_addr,
  input  logic [HALF_W-1:0] wr_data,
  input  logic [2:0]        rd_addr,
  output logic [HALF_W-1:0] rd_data,
  input  logic              cap_in,
  output logic              tmr_out,
  output logic              pwm_out,
  output logic              match_irq,
  output logic              ovf_irq
);

  localparam int NUM_HALVES = 2;
  localparam int CW         = HALF_W * NUM_HALVES;

  mmt_mode_e     mode_q, mode_nxt;
  logic [CW-1:0] data_q, data_nxt;
  logic [CW-1:0] cnt_q, cnt_nxt;
  logic          ctrl_wr, wrap, cap_rise;
  logic          cap_evt, at_data, running, ivl_hit;
  logic          cnt_clr, cnt_inc, match_nxt, ovf_nxt, pwm_nxt;

  mmt_regs #(.HALF_W(HALF_W)) regs_i (
    .clk      (clk),
    .rst      (rst),
    .wr_en    (wr_en),
    .wr_addr  (wr_addr),
    .wr_data  (wr_data),
    .cap_load (cap_evt),
    .cap_value(cnt_q),
    .mode_q   (mode_q),
    .mode_nxt (mode_nxt),
    .data_q   (data_q),
    .data_nxt (data_nxt),
    .ctrl_wr  (ctrl_wr)
  );

  mmt_counter #(.HALF_W(HALF_W), .NUM_HALVES(NUM_HALVES)) cnt_i (
    .clk    (clk),
    .rst    (rst),
    .clr    (cnt_clr),
    .inc    (cnt_inc),
    .cnt    (cnt_q),
    .cnt_nxt(cnt_nxt),
    .wrap   (wrap)
  );

  mmt_capsync #(.STAGES(SYNC_STAGES)) sync_i (
    .clk     (clk),
    .rst     (rst),
    .async_in(cap_in),
    .rise    (cap_rise)
  );

  always_comb begin
    cap_evt   = cap_rise && (mode_q == MODE_CAP);
    at_data   = (cnt_q == data_q);
    running   = (mode_q != MODE_OFF);
    ivl_hit   = tick_en && (mode_q == MODE_IVL) && at_data;
    cnt_clr   = ctrl_wr || ivl_hit || cap_evt;
    cnt_inc   = tick_en && running;
    match_nxt = tick_en && at_data &&
                ((mode_q == MODE_IVL) || (mode_q == MODE_PWM));
    ovf_nxt   = wrap && (mode_q == MODE_CAP) && !ctrl_wr;
    pwm_nxt   = (mode_nxt == MODE_PWM) && (data_nxt > cnt_nxt);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      match_irq <= 1'b0;
      ovf_irq   <= 1'b0;
      tmr_out   <= 1'b0;
      pwm_out   <= 1'b0;
    end else begin
      match_irq <= match_nxt;
      ovf_irq   <= ovf_nxt;
      pwm_out   <= pwm_nxt;
      if (ivl_hit) tmr_out <= ~tmr_out;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_data <= '0;
    end else begin
      case (rd_addr)
        ADR_CTRL: rd_data <= {{(HALF_W-2){1'b0}}, mode_q};
        ADR_DLO:  rd_data <= data_q[HALF_W-1:0];
        ADR_DHI:  rd_data <= data_q[CW-1:HALF_W];
        ADR_CLO:  rd_data <= cnt_q[HALF_W-1:0];
        ADR_CHI:  rd_data <= cnt_q[CW-1:HALF_W];
        default:  rd_data <= '0;
      endcase
    end
  end

endmodule

// File: rtl/mmt_chk.sv
`timescale 1ns/1ps
module mmt_chk
  import mmt_pkg::*;
#(
  parameter int HALF_W = 8,
  localparam int CW    = 2 * HALF_W
) (
  input logic          clk,
  input logic          rst,
  input logic          tick_en,
  input logic          ctrl_wr,
  input mmt_mode_e     mode,
  input logic [CW-1:0] cnt,
  input logic [CW-1:0] data,
  input logic          match_irq,
  input logic          ovf_irq,
  input logic          tmr_out,
  input logic          pwm_out
);

  // R2
  ivl_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (match_irq && mode == MODE_IVL) |-> (cnt == '0));

  // R3
  tmr_toggle_chk: assert property (@(posedge clk) disable iff (rst)
    !$stable(tmr_out) |-> match_irq);

  // R5
  pwm_level_chk: assert property (@(posedge clk) disable iff (rst)
    (mode == MODE_PWM) |-> (pwm_out == (data > cnt)));

  // R5
  pwm_idle_chk: assert property (@(posedge clk) disable iff (rst)
    (mode != MODE_PWM) |-> !pwm_out);

  // R7
  ovf_wrap_chk: assert property (@(posedge clk) disable iff (rst)
    ovf_irq |-> (cnt == '0 && mode == MODE_CAP));

  // R7
  ovf_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    ovf_irq |=> !ovf_irq);

  // R9
  hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!tick_en && !ctrl_wr && mode != MODE_CAP) |=> $stable(cnt));

  // R10
  ctrl_clear_chk: assert property (@(posedge clk) disable iff (rst)
    ctrl_wr |=> (cnt == '0));

endmodule

bind mmt_top mmt_chk #(.HALF_W(HALF_W)) chk_i (
  .clk      (clk),
  .rst      (rst),
  .tick_en  (tick_en),
  .ctrl_wr  (ctrl_wr),
  .mode     (mode_q),
  .cnt      (cnt_q),
  .data     (data_q),
  .match_irq(match_irq),
  .ovf_irq  (ovf_irq),
  .tmr_out  (tmr_out),
  .pwm_out  (pwm_out)
);

// File: tb/mmt_top_tb_top.sv
`timescale 1ns/1ps
module mmt_top_tb_top;

  localparam int HW  = 4;
  localparam int PER = 256;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          tick_en = 1'b0;
  logic          wr_en = 1'b0;
  logic [2:0]    wr_addr = '0;
  logic [HW-1:0] wr_data = '0;
  logic [2:0]    rd_addr = '0;
  logic [HW-1:0] rd_data;
  logic          cap_in = 1'b0;
  logic          tmr_out, pwm_out, match_irq, ovf_irq;

  int n_cmp = 0;
  int n_bad = 0;
  int cyc   = 0;
  bit done  = 1'b0;

  mmt_top #(.HALF_W(HW)) dut_i (
    .clk(clk), .rst(rst), .tick_en(tick_en), .wr_en(wr_en),
    .wr_addr(wr_addr), .wr_data(wr_data), .rd_addr(rd_addr),
    .rd_data(rd_data), .cap_in(cap_in), .tmr_out(tmr_out),
    .pwm_out(pwm_out), .match_irq(match_irq), .ovf_irq(ovf_irq)
  );

  always #10 clk = ~clk;

  always @(negedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 190000 && !done) begin
      n_bad = n_bad + 1;
      $display("FAIL watchdog (all requirements): actual=%0d cycles expected<190000", cyc);
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  task automatic check(input string tag, input int act, input int exp);
    n_cmp = n_cmp + 1;
    if (act != exp) begin
      n_bad = n_bad + 1;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic wr(input int a, input int d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = 3'(a); wr_data = HW'(d);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input int a, output int v);
    @(negedge clk);
    rd_addr = 3'(a);
    @(negedge clk);
    v = int'(rd_data);
  endtask

  task automatic set_data(input int d);
    wr(1, d % 16);
    wr(2, d / 16);
  endtask

  task automatic rd_pair(input int lo_a, output int v);
    int lo, hi;
    rd(lo_a, lo);
    rd(lo_a + 1, hi);
    v = lo + hi * 16;
  endtask

  task automatic run_interval(input int d);
    int k, t0;
    tick_en = 1'b0;
    set_data(d);
    wr(0, 0);
    tick_en = 1'b1;
    k = 0;
    do begin @(negedge clk); k++; end while (!match_irq && k < 1000);
    check($sformatf("R2 first match d=%0d", d), k, d + 1);
    check("R5 pwm low in interval", int'(pwm_out), 0);
    t0 = int'(tmr_out);
    k = 0;
    do begin @(negedge clk); k++; end while (!match_irq && k < 1000);
    check($sformatf("R2 period d=%0d", d), k, d + 1);
    check($sformatf("R3 toggle d=%0d", d), int'(tmr_out), 1 - t0);
    if (d > 0) begin
      @(negedge clk);
      check($sformatf("R3 pulse width d=%0d", d), int'(match_irq), 0);
    end
    tick_en = 1'b0;
  endtask

  task automatic run_pwm(input int d);
    int hi, mc, v;
    tick_en = 1'b0;
    set_data(d);
    wr(0, 1);
    tick_en = 1'b1;
    hi = 0; mc = 0;
    repeat (PER) begin
      @(negedge clk);
      hi += int'(pwm_out);
      mc += int'(match_irq);
    end
    check($sformatf("R5 high time d=%0d", d), hi, d);
    check($sformatf("R4 matches per period d=%0d", d), mc, 1);
    repeat (37) @(negedge clk);
    tick_en = 1'b0;
    rd_pair(3, v);
    check($sformatf("R4 free run count d=%0d", d), v, 37);
  endtask

  task automatic run_capture(input int n);
    int oc, v, lo;
    tick_en = 1'b0;
    set_data(0);
    wr(0, 2);
    tick_en = 1'b1;
    oc = 0;
    repeat (n) begin @(negedge clk); oc += int'(ovf_irq); end
    tick_en = 1'b0;
    check($sformatf("R7 overflow count n=%0d", n), oc, n / PER);
    cap_in = 1'b1;
    repeat (4) @(negedge clk);
    cap_in = 1'b0;
    repeat (2) @(negedge clk);
    rd_pair(1, v);
    check($sformatf("R6 captured n=%0d", n), v, n % PER);
    rd_pair(3, v);
    check($sformatf("R6 count cleared n=%0d", n), v, 0);
    wr(1, 3);
    rd(1, lo);
    check($sformatf("R8 write ignored n=%0d", n), lo, (n % PER) % 16);
  endtask

  initial begin
    int v, oc;
    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R11 reset state
    check("R11 tmr_out", int'(tmr_out), 0);
    check("R11 pwm_out", int'(pwm_out), 0);
    check("R11 match_irq", int'(match_irq), 0);
    check("R11 ovf_irq", int'(ovf_irq), 0);
    for (int a = 0; a < 5; a++) begin
      rd(a, v);
      check($sformatf("R11 reg %0d", a), v, 0);
    end

    // R1 register map readback
    set_data(8'hA5);
    rd(1, v); check("R1 data low", v, 5);
    rd(2, v); check("R1 data high", v, 10);
    wr(0, 1);
    rd(0, v); check("R1 mode readback", v, 1);

    // R2 R3 interval sweep, including a 0x24 example split across halves
    for (int d = 0; d < PER; d += (d < 4) ? 1 : 29) run_interval(d);
    run_interval(8'h24);
    run_interval(255);

    // R4 R5 PWM sweep
    for (int d = 0; d < PER; d += 51) run_pwm(d);
    run_pwm(1);
    run_pwm(128);

    // R10 control write clears pwm_out
    tick_en = 1'b0;
    set_data(200);
    wr(0, 1);
    check("R5 pwm high at start", int'(pwm_out), 1);
    wr(0, 0);
    check("R10 pwm cleared on ctrl write", int'(pwm_out), 0);

    // R6 R7 R8 capture sweep
    run_capture(5);
    run_capture(255);
    run_capture(300);
    run_capture(600);

    // R7 capture and wrap on the same tick
    tick_en = 1'b0;
    wr(0, 2);
    tick_en = 1'b1;
    repeat (253) @(negedge clk);
    cap_in = 1'b1;
    oc = 0;
    repeat (3) begin @(negedge clk); oc += int'(ovf_irq); end
    tick_en = 1'b0;
    cap_in = 1'b0;
    repeat (2) begin @(negedge clk); oc += int'(ovf_irq); end
    check("R7 overflow with capture", oc, 1);
    rd_pair(1, v);
    check("R7 captured at wrap", v, 255);
    rd_pair(3, v);
    check("R7 count after capture", v, 0);

    // R9 tick gating
    wr(0, 1);
    tick_en = 1'b1;
    repeat (10) @(negedge clk);
    tick_en = 1'b0;
    repeat (20) @(negedge clk);
    rd_pair(3, v);
    check("R9 hold without tick", v, 10);
    for (int i = 0; i < 20; i++) begin
      tick_en = (i % 2) == 1;
      @(negedge clk);
    end
    tick_en = 1'b0;
    rd_pair(3, v);
    check("R9 alternate ticks", v, 20);

    // R10 control write clears counter; mode 11 stays stopped
    wr(0, 1);
    rd_pair(3, v);
    check("R10 count cleared", v, 0);
    wr(0, 3);
    tick_en = 1'b1;
    repeat (15) @(negedge clk);
    tick_en = 1'b0;
    rd_pair(3, v);
    check("R10 mode 11 stopped", v, 0);

    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule